// File: doc/BRIEF.md
# Multi-mode half-bridge PWM controller

The block drives one half bridge through two outputs: `out_a` for the high side and `out_b` for the low side. A prescaler produces a count enable for a counter that is 14 bits wide with the default parameters. Four programmable 12-bit segment values set the waveform. They are two dead times and two on-times, one pair for each output. The same four values are read in a different way in each of four run modes:

- Four-ramp mode uses four consecutive segments.
- Two-ramp mode uses two cumulative ramps.
- One-ramp mode uses a single shared ramp, on which the outputs may overlap.
- Centered mode uses a symmetric up/down count.

Segment values are written through a parallel load port into a shadow set. The active set takes a copy of the shadow set only at a cycle start. A retrigger input restarts the cycle at once. A fault input latches a fault state that forces both outputs low. A one-clock `sync_out` pulse marks each cycle start. A second instance can restart from that pulse through `sync_in` when its `slave_en` is high, which chains several instances. The active-low reset is asserted asynchronously and is released through a two-flop synchronizer.

Top module: `hb_pwm_ctrl`

## Requirements
- R1: While reset is held, and after reset while `run` is low, `out_a`, `out_b` and `sync_out` are 0.
- R2: With `mode`=4 (four-ramp), the count runs 0..P-1 with P=dA+oA+dB+oB. `out_a` is high for counts in [dA, dA+oA). `out_b` is high for counts in [dA+oA+dB, P).
- R3: With `mode`=2 (two-ramp), P=oA+oB, where oA and oB each include their dead time. `out_a` is high for counts in [dA, oA). `out_b` is high for counts in [oA+dB, oA+oB).
- R4: With `mode`=1 (one-ramp), P=oB. `out_a` is high for counts in [dA, oA) and `out_b` for counts in [dB, oB). The two may be high together.
- R5: With `mode`=0 (centered), the count goes 0,1..T and then T-1..1, with T=oB and a period of 2T count steps. `out_a` is high while count>=dA and `out_b` while count>=dB.
- R6: In modes 4 and 2, `out_a` and `out_b` are never high in the same clock.
- R7: `pre_sel` values 0, 1, 2 and 3 hold each count value for 1, 4, 16 and 64 clocks.
- R8: A load with `ld_en` writes `ld_data` into shadow register `ld_sel`. The encoding is 0=dA, 1=oA, 2=dB, 3=oB. The active set copies the shadow set only when a new cycle begins: at the natural cycle end, on a restart, or in every clock while stopped or faulted.
- R9: A clock edge with `retrig_in` high makes the next count 0 with a fresh prescale phase, so the waveform restarts at index 0.
- R10: An edge with `fault_in` high latches a fault. From the next clock both outputs are low and `sync_out` stays low. `fault_clr` clears the fault only in a clock where `fault_in` is low. After the clear, the cycle restarts from count 0.
- R11: `sync_out` is high for exactly the first clock of each cycle. An edge with `sync_in` high restarts the cycle like R9 when `slave_en` is 1, and has no effect when `slave_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables counting and outputs |
| mode | input | 3 | Run mode: 4, 2, 1 or 0 (centered) |
| pre_sel | input | 2 | Prescale select: divide by 1, 4, 16 or 64 |
| ld_en | input | 1 | Write strobe for a shadow segment register |
| ld_sel | input | 2 | Shadow register index (0=dA, 1=oA, 2=dB, 3=oB) |
| ld_data | input | 12 | Value written to the selected shadow register |
| retrig_in | input | 1 | Restarts the cycle immediately |
| fault_in | input | 1 | Latches the fault state |
| fault_clr | input | 1 | Clears the fault state |
| sync_in | input | 1 | Cycle-start pulse from a master instance |
| slave_en | input | 1 | Lets `sync_in` restart the cycle |
| out_a | output | 1 | High-side drive |
| out_b | output | 1 | Low-side drive |
| sync_out | output | 1 | One-clock pulse at each cycle start |

## Verification
The hardest case to reach is a shadow write that lands in the middle of a running cycle, while the active on-time is still needed to finish that cycle. The stimulus starts a four-ramp cycle and writes a shorter A on-time while `out_a` is high. It then checks that the pulse still ends at the old boundary, and that the new width first appears in the following cycle. A fault is also raised with `fault_clr` applied in the same clock, to show that the clear loses to a fault that is still present.

// File: rtl/hb_pwm_pkg.sv
package hb_pwm_pkg;
  typedef enum logic [2:0] {
    MODE_CTR  = 3'd0,
    MODE_ONE  = 3'd1,
    MODE_TWO  = 3'd2,
    MODE_FOUR = 3'd4
  } hb_mode_e;
endpackage

// File: rtl/hb_pwm_presc.sv
module hb_pwm_presc #(
  parameter int PSW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic [1:0]     sel,
  output logic           tick,
  output logic [PSW-1:0] phase
);
  logic [PSW-1:0] pcnt_q, pcnt_d, mask;

  always_comb begin
    for (int k = 0; k < PSW; k++) mask[k] = (k < 2 * int'(sel));
  end

  assign tick  = (pcnt_q & mask) == mask;
  assign phase = pcnt_q;

  always_comb begin
    if (clr || tick) pcnt_d = '0;
    else             pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R7: above divide-by-1, two ticks never come back to back
  a_r7_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != 2'd0 && tick && !clr) |=> !tick);
endmodule

// File: rtl/hb_pwm_cnt.sv
module hb_pwm_cnt #(
  parameter int CNTW = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic            restart,
  input  logic            tick,
  input  logic            is_ctr,
  input  logic [CNTW-1:0] per_len,
  input  logic [CNTW-1:0] top,
  output logic [CNTW-1:0] cnt,
  output logic            up,
  output logic            load
);
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            up_q, up_d;
  logic [CNTW:0]   nxt_ext;

  assign nxt_ext = {1'b0, cnt_q} + {{CNTW{1'b0}}, 1'b1};

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    load  = 1'b0;
    if (hold || restart) begin
      cnt_d = '0; up_d = 1'b1; load = 1'b1;
    end else if (tick) begin
      if (is_ctr) begin
        if (up_q) begin
          if (top == '0) begin
            cnt_d = '0; load = 1'b1;
          end else if (cnt_q >= top) begin
            up_d = 1'b0; cnt_d = cnt_q - 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else if (cnt_q <= {{(CNTW-1){1'b0}}, 1'b1}) begin
          cnt_d = '0; up_d = 1'b1; load = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end else if (nxt_ext >= {1'b0, per_len}) begin
        cnt_d = '0; load = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt = cnt_q;
  assign up  = up_q;

  // R9: a restart leaves the counter at zero, counting up
  a_r9_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !hold) |=> (cnt_q == '0 && up_q));
  // R2: linear modes never count past the period
  a_r2_below_period: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_ctr && per_len != '0) |-> (cnt_q < per_len));
  // R5: the centered count never exceeds its top
  a_r5_within_top: assert property (@(posedge clk) disable iff (!rst_n)
    is_ctr |-> (cnt_q <= top));
endmodule

// File: rtl/hb_pwm_dec.sv
module hb_pwm_dec
  import hb_pwm_pkg::*;
#(
  parameter int CW   = 12,
  parameter int CNTW = 14
) (
  input  hb_mode_e        mode,
  input  logic [CW-1:0]   dly_a,
  input  logic [CW-1:0]   on_a,
  input  logic [CW-1:0]   dly_b,
  input  logic [CW-1:0]   on_b,
  input  logic [CNTW-1:0] cnt,
  output logic            win_a,
  output logic            win_b,
  output logic            is_ctr,
  output logic [CNTW-1:0] per_len,
  output logic [CNTW-1:0] top
);
  logic [CNTW-1:0] da, oa, db, ob, a_end4, b_beg4, p4, b_beg2, p2;

  assign da = CNTW'(dly_a);
  assign oa = CNTW'(on_a);
  assign db = CNTW'(dly_b);
  assign ob = CNTW'(on_b);

  assign a_end4 = da + oa;
  assign b_beg4 = a_end4 + db;
  assign p4     = b_beg4 + ob;
  assign b_beg2 = oa + db;
  assign p2     = oa + ob;
  assign top    = ob;

  always_comb begin
    win_a   = 1'b0;
    win_b   = 1'b0;
    is_ctr  = 1'b0;
    per_len = p4;
    case (mode)
      MODE_FOUR: begin
        win_a = (cnt >= da) && (cnt < a_end4);
        win_b = (cnt >= b_beg4) && (cnt < p4);
      end
      MODE_TWO: begin
        per_len = p2;
        win_a   = (cnt >= da) && (cnt < oa);
        win_b   = (cnt >= b_beg2) && (cnt < p2);
      end
      MODE_ONE: begin
        per_len = ob;
        win_a   = (cnt >= da) && (cnt < oa);
        win_b   = (cnt >= db) && (cnt < ob);
      end
      MODE_CTR: begin
        is_ctr = 1'b1;
        win_a  = cnt >= da;
        win_b  = cnt >= db;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hb_pwm_ctrl.sv
module hb_pwm_ctrl
  import hb_pwm_pkg::*;
#(
  parameter int CW  = 12,
  parameter int PSW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [2:0]    mode,
  input  logic [1:0]    pre_sel,
  input  logic          ld_en,
  input  logic [1:0]    ld_sel,
  input  logic [CW-1:0] ld_data,
  input  logic          retrig_in,
  input  logic          fault_in,
  input  logic          fault_clr,
  input  logic          sync_in,
  input  logic          slave_en,
  output logic          out_a,
  output logic          out_b,
  output logic          sync_out
);
  localparam int CNTW = CW + 2;
  localparam int NSEG = 4;

  logic [1:0] rsync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  logic [NSEG-1:0][CW-1:0] shd_q, shd_d, act_q, act_d;
  logic                    fault_q, fault_d;
  logic                    hold, restart, tick, load, win_a, win_b, is_ctr, up;
  logic [PSW-1:0]          phase;
  logic [CNTW-1:0]         cnt, per_len, top;
  hb_mode_e                md;

  assign md      = hb_mode_e'(mode);
  assign hold    = !run || fault_q;
  assign restart = retrig_in || (sync_in && slave_en);

  always_comb begin
    fault_d = fault_q;
    if (fault_in)       fault_d = 1'b1;
    else if (fault_clr) fault_d = 1'b0;
  end

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    always_comb begin
      shd_d[g] = shd_q[g];
      if (ld_en && ld_sel == 2'(g)) shd_d[g] = ld_data;
      act_d[g] = load ? shd_q[g] : act_q[g];
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      shd_q   <= '0;
      act_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      shd_q   <= shd_d;
      act_q   <= act_d;
      fault_q <= fault_d;
    end
  end

  hb_pwm_presc #(.PSW(PSW)) u_presc (
    .clk(clk), .rst_n(rst_i), .clr(hold || restart), .sel(pre_sel),
    .tick(tick), .phase(phase)
  );

  hb_pwm_cnt #(.CNTW(CNTW)) u_cnt (
    .clk(clk), .rst_n(rst_i), .hold(hold), .restart(restart), .tick(tick),
    .is_ctr(is_ctr), .per_len(per_len), .top(top),
    .cnt(cnt), .up(up), .load(load)
  );

  hb_pwm_dec #(.CW(CW), .CNTW(CNTW)) u_dec (
    .mode(md), .dly_a(act_q[0]), .on_a(act_q[1]), .dly_b(act_q[2]), .on_b(act_q[3]),
    .cnt(cnt), .win_a(win_a), .win_b(win_b), .is_ctr(is_ctr),
    .per_len(per_len), .top(top)
  );

  assign out_a    = run && !fault_q && win_a;
  assign out_b    = run && !fault_q && win_b;
  assign sync_out = run && !fault_q && up && (cnt == '0) && (phase == '0);

  // R6: no cross-conduction in the non-overlapping modes
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_i)
    (md == MODE_FOUR || md == MODE_TWO) |-> !(out_a && out_b));
  // R8: the active set only changes as a new cycle begins
  a_r8_swap_at_start: assert property (@(posedge clk) disable iff (!rst_i)
    !$stable(act_q) |-> (cnt == '0));
  // R10: a sampled fault silences both outputs in the next clock
  a_r10_fault_quiet: assert property (@(posedge clk) disable iff (!rst_i)
    $past(fault_in) |-> (!out_a && !out_b && !sync_out));
  // R11: a restart is announced by a sync pulse
  a_r11_sync_on_restart: assert property (@(posedge clk) disable iff (!rst_i)
    (retrig_in && run && !fault_q && !fault_in) |=> (sync_out || !run));
endmodule

// File: tb/sim_hb_pwm_ctrl.sv
module sim_hb_pwm_ctrl;
  logic        clk = 1'b0;
  logic        rst_n, run, ld_en, retrig_in, fault_in, fault_clr, sync_in, slave_en;
  logic [2:0]  mode;
  logic [1:0]  pre_sel, ld_sel;
  logic [11:0] ld_data;
  logic        out_a, out_b, sync_out;

  int n_cmp = 0, n_bad = 0, n_both = 0, cur = 0;
  int m_mode = 4, m_div = 1, r_da = 0, r_oa = 0, r_db = 0, r_ob = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hb_pwm_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .pre_sel(pre_sel),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data), .retrig_in(retrig_in),
    .fault_in(fault_in), .fault_clr(fault_clr), .sync_in(sync_in),
    .slave_en(slave_en), .out_a(out_a), .out_b(out_b), .sync_out(sync_out)
  );

  task automatic chk(string tag, string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s idx %0d: actual %b expected %b", tag, what, cur, act, exp);
    end
  endtask

  function automatic void model(int i, output logic ea, output logic eb, output logic es);
    int s, p, c, ph;
    logic upd;
    s = i / m_div;
    upd = 1'b1;
    ea = 1'b0; eb = 1'b0;
    if (m_mode == 0) begin
      ph  = (r_ob == 0) ? 0 : s % (2 * r_ob);
      c   = (ph <= r_ob) ? ph : 2 * r_ob - ph;
      upd = ph <= r_ob;
      ea  = c >= r_da;
      eb  = c >= r_db;
    end else begin
      p = (m_mode == 4) ? r_da + r_oa + r_db + r_ob :
          (m_mode == 2) ? r_oa + r_ob : r_ob;
      c = s % p;
      if (m_mode == 4) begin
        ea = c >= r_da && c < r_da + r_oa;
        eb = c >= r_da + r_oa + r_db && c < p;
      end else if (m_mode == 2) begin
        ea = c >= r_da && c < r_oa;
        eb = c >= r_oa + r_db && c < p;
      end else begin
        ea = c >= r_da && c < r_oa;
        eb = c >= r_db && c < r_ob;
      end
    end
    es = (c == 0) && upd && (i % m_div == 0);
  endfunction

  task automatic span(int start, int n, string tag);
    for (int i = start; i < start + n; i++) begin
      logic ea, eb, es;
      #1;
      cur = i;
      model(i, ea, eb, es);
      chk(tag, "out_a", out_a, ea);
      chk(tag, "out_b", out_b, eb);
      chk("R11", "sync_out", sync_out, es);
      if (out_a && out_b) n_both++;
      @(negedge clk);
    end
  endtask

  task automatic quiet(int n, string tag);
    for (int i = 0; i < n; i++) begin
      #1;
      cur = i;
      chk(tag, "out_a", out_a, 1'b0);
      chk(tag, "out_b", out_b, 1'b0);
      chk(tag, "sync_out", sync_out, 1'b0);
      @(negedge clk);
    end
  endtask

  task automatic cfg(int md, int sel);
    @(negedge clk);
    run = 1'b0;
    mode = md[2:0];
    pre_sel = sel[1:0];
    m_mode = md;
    m_div = 1 << (2 * sel);
  endtask

  task automatic wr(int sel, int v);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = sel[1:0]; ld_data = v[11:0];
  endtask

  task automatic load(int da, int oa, int db, int ob);
    wr(0, da); wr(1, oa); wr(2, db); wr(3, ob);
    @(negedge clk);
    ld_en = 1'b0;
    r_da = da; r_oa = oa; r_db = db; r_ob = ob;
  endtask

  task automatic go();
    @(negedge clk);
    @(negedge clk);
    run = 1'b1;
    n_both = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; run = 1'b0; ld_en = 1'b0; retrig_in = 1'b0; fault_in = 1'b0;
    fault_clr = 1'b0; sync_in = 1'b0; slave_en = 1'b0; mode = 3'd4; pre_sel = 2'd0;
    ld_sel = 2'd0; ld_data = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "out_a in reset", out_a, 1'b0);
    chk("R1", "out_b in reset", out_b, 1'b0);
    chk("R1", "sync_out in reset", sync_out, 1'b0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    quiet(4, "R1");
  endtask

  task automatic t_four();
    cfg(4, 0); load(50, 75, 100, 125); go();
    span(0, 720, "R2");
    n_cmp++;
    if (n_both != 0) begin
      n_bad++;
      $display("FAIL R6 four-ramp overlap: actual %0d expected 0", n_both);
    end
  endtask

  task automatic t_two();
    cfg(2, 0); load(50, 75, 100, 125); go();
    span(0, 420, "R3");
    n_cmp++;
    if (n_both != 0) begin
      n_bad++;
      $display("FAIL R6 two-ramp overlap: actual %0d expected 0", n_both);
    end
  endtask

  task automatic t_one();
    cfg(1, 0); load(50, 100, 75, 125); go();
    span(0, 250, "R4");
    n_cmp++;
    if (n_both != 50) begin
      n_bad++;
      $display("FAIL R4 overlap clocks: actual %0d expected 50", n_both);
    end
  endtask

  task automatic t_center();
    cfg(0, 0); load(20, 5, 40, 60); go();
    span(0, 260, "R5");
  endtask

  task automatic t_presc();
    cfg(4, 1); load(2, 3, 2, 3); go();
    span(0, 100, "R7");
    cfg(4, 2); load(2, 3, 2, 3); go();
    span(0, 200, "R7");
    cfg(4, 3); load(1, 1, 1, 1); go();
    span(0, 520, "R7");
  endtask

  task automatic t_dbuf();
    cfg(4, 0); load(50, 75, 100, 125); go();
    span(0, 100, "R8");
    ld_en = 1'b1; ld_sel = 2'd1; ld_data = 12'd30;
    @(negedge clk);
    ld_en = 1'b0;
    span(101, 249, "R8");
    r_oa = 30;
    span(0, 330, "R8");
  endtask

  task automatic t_retrig();
    cfg(4, 0); load(50, 75, 100, 125); go();
    span(0, 90, "R9");
    retrig_in = 1'b1;
    @(negedge clk);
    retrig_in = 1'b0;
    span(0, 130, "R9");
  endtask

  task automatic t_fault();
    cfg(4, 0); load(50, 75, 100, 125); go();
    span(0, 60, "R10");
    fault_in = 1'b1;
    @(negedge clk);
    fault_in = 1'b0;
    quiet(20, "R10");
    fault_in = 1'b1; fault_clr = 1'b1;
    @(negedge clk);
    fault_in = 1'b0; fault_clr = 1'b0;
    quiet(6, "R10");
    fault_clr = 1'b1;
    @(negedge clk);
    fault_clr = 1'b0;
    span(0, 150, "R10");
  endtask

  task automatic t_sync();
    cfg(4, 0); load(10, 20, 10, 20); go();
    slave_en = 1'b0;
    span(0, 40, "R11");
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    span(41, 50, "R11");
    slave_en = 1'b1; sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    span(0, 70, "R11");
    slave_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_four();
    t_two();
    t_one();
    t_center();
    t_presc();
    t_dbuf();
    t_retrig();
    t_fault();
    t_sync();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual still running, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule